// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core. It holds an 8-bit enable register, a 5-bit pending-flag register and a single master enable bit. The sources occupy flag bits in a fixed order: bit 0 is vertical blank, bit 1 is display status, bit 2 is timer overflow, bit 3 is serial transfer done and bit 4 is a keypad falling edge. Each source pulse sets its flag bit, whatever the enable register holds.

The core pulses `boundary` at each instruction boundary. In that cycle the block decides whether to enter service. On entry it picks the lowest-numbered source that is both enabled and pending, and clears only that flag bit. It also clears the master enable and wakes the core from halt. One cycle later it presents a one-cycle `take` strobe with the restart address. The core itself handles stacking the program counter and the jump.

Top module: `irq_arbiter`

## Requirements
- R1: Entry happens only on a `boundary` cycle in which the master enable is set, the full 8-bit enable register is nonzero and the flag register is nonzero. In any other cycle, `take` and `wake` stay low.
- R2: Among the bits set in both the enable and flag registers, bit 0 wins, then bits 1, 2, 3 and 4 in that order. Each entry serves exactly one source.
- R3: The vector for source bit n is 0x40 + 8*n, so the five vectors are 0x40, 0x48, 0x50, 0x58 and 0x60.
- R4: Serving a source clears only that source's flag bit. All other pending bits are left unchanged.
- R5: Every entry clears the master enable (`irq_master` low) and raises `wake` for one cycle, in the same cycle as `take`.
- R6: If entry happens but no bit among 0 to 4 is both enabled and pending, then `take` stays low, no flag bit changes, `wake` still pulses and the master enable ends up set.
- R7: A `src_req` bit sets its flag bit on the next clock edge even when the matching enable bit is clear. When a CPU flag write happens in the same cycle, the source set wins.
- R8: `reg_sel`=0 selects the enable register, which reads back all 8 written bits. `reg_sel`=1 selects the flag register. Only bits 4:0 of the flag register are writable, and bits 7:5 always read as ones.
- R9: `take` and `vector` are registered. They appear in the cycle after the `boundary` cycle and last for exactly one cycle. At all other times `vector` reads 0.
- R10: `ei` sets the master enable and `di` clears it. An entry in the same cycle overrides `ei`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 5 | Source request pulses, bit 0 = vertical blank ... bit 4 = keypad |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = flag register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ei | input | 1 | Set master enable |
| di | input | 1 | Clear master enable |
| boundary | input | 1 | Instruction-boundary strobe |
| take | output | 1 | One-cycle take-interrupt strobe |
| vector | output | 8 | Restart address, valid with `take` |
| wake | output | 1 | One-cycle halt-release pulse |
| irq_master | output | 1 | Current master enable |

## Verification
A wrong priority pick or a wrong vector shows on `vector` in the cycle after the boundary. A wrong clear shows on the flag readback one cycle later. Flag or master state that drifts stays hidden until the next boundary, where it shows up as an entry that is missing, extra or wrong. For this reason the bench checks every combination of enable and flag values, including an enable bit outside the five sources. Because the flag register is read back right after each entry, a stale bit shows within two cycles.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int          NSRC     = 5,
  parameter logic [7:0]  VEC_BASE = 8'h40,
  parameter int          VEC_STEP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            ei,
  input  logic            di,
  input  logic            boundary,
  output logic            take,
  output logic [7:0]      vector,
  output logic            wake,
  output logic            irq_master
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [7:0]      ie_q;
  logic [NSRC-1:0] flag_q, flag_d, pend, clr;
  logic            ime_q, take_q, wake_q, enter, hit;
  logic [IW-1:0]   idx;
  logic [7:0]      vec_q, vec_d;

  assign pend  = ie_q[NSRC-1:0] & flag_q;
  assign enter = boundary && ime_q && (ie_q != 8'h00) && (flag_q != '0);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  assign vec_d = VEC_BASE + 8'(int'(idx) * VEC_STEP);
  assign clr   = (enter && hit) ? (NSRC'(1) << idx) : '0;

  always_comb begin
    flag_d = (reg_wr && reg_sel) ? reg_wdata[NSRC-1:0] : flag_q;
    flag_d = (flag_d & ~clr) | src_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 8'h00;
      flag_q <= '0;
      ime_q  <= 1'b0;
      take_q <= 1'b0;
      wake_q <= 1'b0;
      vec_q  <= 8'h00;
    end else begin
      if (reg_wr && !reg_sel) ie_q <= reg_wdata;
      flag_q <= flag_d;
      if (enter)   ime_q <= !hit;
      else if (ei) ime_q <= 1'b1;
      else if (di) ime_q <= 1'b0;
      take_q <= enter && hit;
      wake_q <= enter;
      vec_q  <= (enter && hit) ? vec_d : 8'h00;
    end
  end

  assign reg_rdata  = reg_sel ? {{(8-NSRC){1'b1}}, flag_q} : ie_q;
  assign take       = take_q;
  assign vector     = vec_q;
  assign wake       = wake_q;
  assign irq_master = ime_q;

  logic [7:0] vidx;
  assign vidx = (vec_q - VEC_BASE) / 8'(VEC_STEP);

  // R1
  take_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary) && $past(ime_q));

  // R5
  take_master_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !irq_master && wake);

  // R9
  take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // R3
  vec_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((vec_q - VEC_BASE) % 8'(VEC_STEP)) == 8'h00 && vidx < 8'(NSRC));

  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !flag_q[vidx[IW-1:0]] || $past(src_req[vidx[IW-1:0]])
             || $past(reg_wr && reg_sel));

  // R9
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> vector == 8'h00);
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_req = '0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0, ei = 1'b0, di = 1'b0, boundary = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, vector;
  logic       take, wake, irq_master;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_arbiter u_dut (.clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ei(ei), .di(di),
    .boundary(boundary), .take(take), .vector(vector), .wake(wake), .irq_master(irq_master));

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; tick(); reg_wr = 1'b0;
  endtask

  task automatic rd_flag(output logic [7:0] v);
    reg_sel = 1'b1; #1 v = reg_rdata;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    tick(); tick(); rst_n = 1'b1; tick();
    reg_sel = 1'b0; #1 check(reg_rdata, 8'h00, "reset ie R8");
    rd_flag(v); check(v, 8'he0, "reset flag R8");
    check(take, 0, "reset take R9"); check(irq_master, 0, "reset master R10");

    // R1: pending and enabled but master off
    wr(0, 8'h1f); wr(1, 8'h1f); boundary = 1; tick(); boundary = 0;
    check(take, 0, "no master take R1"); check(wake, 0, "no master wake R1");
    rd_flag(v); check(v, 8'hff, "no master flag R1");

    // R8 readback
    wr(0, 8'ha5); reg_sel = 0; #1 check(reg_rdata, 8'ha5, "ie readback R8");
    wr(1, 8'h0a); rd_flag(v); check(v, 8'hea, "flag readback R8");

    // Sweep: R1 R2 R3 R4 R5 R6 R9
    for (int e = 0; e < 64; e++) begin
      for (int f = 0; f < 32; f++) begin
        int pend, lb; bit entry;
        wr(0, 8'(e)); wr(1, 8'(f));
        ei = 1; tick(); ei = 0;
        boundary = 1; tick(); boundary = 0;
        entry = (e != 0) && (f != 0);
        pend = e & f & 31;
        lb = 0;
        for (int b = 4; b >= 0; b--) if (pend[b]) lb = b;
        check(take, (entry && pend != 0) ? 1 : 0, "sweep take R2");
        check(vector, (entry && pend != 0) ? 8'h40 + 8 * lb : 0, "sweep vector R3");
        check(wake, entry ? 1 : 0, "sweep wake R5");
        check(irq_master, (entry && pend != 0) ? 0 : 1, "sweep master R6");
        rd_flag(v);
        check(v, 8'he0 | ((entry && pend != 0) ? (f & ~(1 << lb)) : f), "sweep flag R4");
        tick();
        check(take, 0, "take width R9"); check(vector, 0, "vector idle R9");
      end
    end

    // R2: sequential service of remaining sources
    wr(0, 8'h1f); wr(1, 8'h1a);
    for (int k = 0; k < 3; k++) begin
      int expb;
      expb = (k == 0) ? 1 : (k == 1) ? 3 : 4;
      ei = 1; tick(); ei = 0; boundary = 1; tick(); boundary = 0;
      check(vector, 8'h40 + 8 * expb, "chain vector R2");
    end
    rd_flag(v); check(v, 8'he0, "chain empty R4");

    // R7: source set with enable clear, and beats a same-cycle write
    wr(0, 8'h00); wr(1, 8'h00);
    src_req = 5'h10; tick(); src_req = 0;
    rd_flag(v); check(v, 8'hf0, "src set no enable R7");
    reg_wr = 1; reg_sel = 1; reg_wdata = 8'h00; src_req = 5'h04; tick();
    reg_wr = 0; src_req = 0;
    rd_flag(v); check(v, 8'he4, "src beats write R7");

    // R10: ei/di and entry over ei
    ei = 1; tick(); ei = 0; check(irq_master, 1, "ei sets R10");
    di = 1; tick(); di = 0; check(irq_master, 0, "di clears R10");
    wr(0, 8'h04); ei = 1; tick();
    boundary = 1; tick(); ei = 0; boundary = 0;
    check(take, 1, "entry with ei take R10");
    check(irq_master, 0, "entry beats ei R10");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule